// File: doc/BRIEF.md
# Ethernet MAC Event Statistics Counter Bank

This block keeps fourteen error and event counters for an Ethernet MAC: seven on the receive side and seven on the transmit side. Each one-cycle event strobe from the MAC adds one to its counter. When a counter passes its all-ones value, it returns to zero. In the same cycle the wrap sets a sticky bit in one of two carry registers. Software can extend the hardware counts with these carry bits. A carry bit whose mask bit is zero drives the interrupt output.

Software reads and writes the counters, the carry registers and the mask registers through a single-cycle register port. A write loads a counter, and writing zero resets it. A carry register is cleared by writing ones back over the bits that were read. A mask register is written directly.

Top module: `mac_stat_bank`

## Requirements
- R1: Each counter adds exactly one on every clock cycle in which its event bit is high. Any mix of event bits may be high in the same cycle. Event bit index i of `rx_evt` and `tx_evt` matches counter i in the address map of R10.
- R2: The receive alignment counter is 12 bits wide. The six other receive counters are 16 bits wide. All seven transmit counters are 12 bits wide. A counter holding all ones goes to zero on its next event. A written value keeps only the counter's width.
- R3: A receive counter wrap sets the following bit of carry register 1 in the same cycle: fcs 6, alignment 8, length 7, drop 0, code 14, overflow 3, fragment 2.
- R4: A transmit counter wrap sets the following bit of carry register 2 in the same cycle: single 6, deferred 8, multiple 5, late 4, total 2, oversize 16, underrun 15.
- R5: Writing a carry register clears each bit that is written as 1 and leaves bits written as 0 unchanged. A wrap that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R6: A carry bit stays set until it is cleared by a write. Bit positions not listed in R3 and R4 always read 0.
- R7: Both mask registers reset to all ones, and a write stores the full 32-bit value.
- R8: `irq` is high exactly when some carry bit is set and the mask bit at the same position of its mask register is 0.
- R9: A write to a counter loads the low bits of `wdata`, so writing zero resets the counter. A write takes priority over an event in the same cycle.
- R10: Address map: 0 to 6 are the receive counters in the order fcs, alignment, length, drop, code, overflow, fragment. 8 to 14 are the transmit counters in the order single, deferred, multiple, late, total, oversize, underrun. 16 is carry register 1, 17 is carry register 2, 18 is mask 1 and 19 is mask 2. Any other address reads 0. After reset, every counter and carry register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_evt | input | 7 | Receive event strobes, one bit per receive counter |
| tx_evt | input | 7 | Transmit event strobes, one bit per transmit counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Unmasked carry pending |

## Verification
An event strobe or a register write takes effect at the one rising edge where it is held. The new counter value, the carry bit and `irq` can all be seen right after that edge, because `rdata` and `irq` are decoded combinationally from registers. The bench drives every input at the falling edge. It releases the inputs at the next falling edge, after exactly one rising edge. It then sets `addr` and samples `rdata` and `irq` 1 ns later, well before the following rising edge. In this way each result is observed in the cycle in which it is due. The internal reset synchronizer adds two cycles, and the bench waits for them before it checks the reset state.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int RX_N  = 7;
  localparam int TX_N  = 7;
  localparam int REG_W = 32;

  // Index order: fcs, align, length, drop, code, overflow, fragment
  localparam int RX_CARRY_POS [RX_N] = '{6, 8, 7, 0, 14, 3, 2};
  // Index order: single, deferred, multiple, late, total, oversize, underrun
  localparam int TX_CARRY_POS [TX_N] = '{6, 8, 5, 4, 2, 16, 15};

  localparam int RX_NARROW_IDX = 1;

  localparam int A_RX_BASE = 0;
  localparam int A_TX_BASE = 8;
  localparam int A_CARRY1  = 16;
  localparam int A_CARRY2  = 17;
  localparam int A_MASK1   = 18;
  localparam int A_MASK2   = 19;

  function automatic logic [REG_W-1:0] carry_valid(input bit rx_side);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < RX_N; i++) begin
      if (rx_side) m[RX_CARRY_POS[i]] = 1'b1;
      else         m[TX_CARRY_POS[i]] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld | evt;
    if (ld) cnt_d = ld_val;
    else    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = evt & ~ld & (&cnt_q);
endmodule

// File: rtl/mac_stat_carry.sv
module mac_stat_carry #(
  parameter int              REG_W = 32,
  parameter logic [REG_W-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             clr_wr,
  input  logic             mask_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] carry,
  output logic [REG_W-1:0] mask,
  output logic             pend
);
  logic [REG_W-1:0] carry_q, carry_d, clr_vec;
  logic [REG_W-1:0] mask_q;
  logic             carry_en;

  always_comb begin
    clr_vec  = clr_wr ? wdata : '0;
    carry_d  = ((carry_q & ~clr_vec) | set_vec) & VALID;
    carry_en = clr_wr | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= '0;
    else if (carry_en) carry_q <= carry_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= wdata;
  end

  assign carry = carry_q;
  assign mask  = mask_q;
  assign pend  = |(carry_q & ~mask_q);
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  localparam logic [REG_W-1:0] C1_VALID = carry_valid(1'b1);
  localparam logic [REG_W-1:0] C2_VALID = carry_valid(1'b0);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [RX_N-1:0]  rx_wrap;
  logic [TX_N-1:0]  tx_wrap;
  logic [WIDE_W-1:0] rx_cnt [RX_N];
  logic [WIDE_W-1:0] tx_cnt [TX_N];
  logic [REG_W-1:0] rx_set, tx_set;
  logic [REG_W-1:0] carry1_q, carry2_q, mask1_q, mask2_q;
  logic             pend1, pend2;

  // Reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar i = 0; i < RX_N; i++) begin : g_rx
    localparam int W = (i == RX_NARROW_IDX) ? NARROW_W : WIDE_W;
    logic [W-1:0] c;
    mac_stat_ctr #(.W(W)) ctr_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .evt    (rx_evt[i]),
      .ld     (wr_en && (addr == ADDR_W'(A_RX_BASE + i))),
      .ld_val (wdata[W-1:0]),
      .cnt    (c),
      .wrap   (rx_wrap[i])
    );
    assign rx_cnt[i] = WIDE_W'(c);
  end

  for (genvar i = 0; i < TX_N; i++) begin : g_tx
    logic [NARROW_W-1:0] c;
    mac_stat_ctr #(.W(NARROW_W)) ctr_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .evt    (tx_evt[i]),
      .ld     (wr_en && (addr == ADDR_W'(A_TX_BASE + i))),
      .ld_val (wdata[NARROW_W-1:0]),
      .cnt    (c),
      .wrap   (tx_wrap[i])
    );
    assign tx_cnt[i] = WIDE_W'(c);
  end

  // Route wraps to their fixed carry positions
  always_comb begin
    rx_set = '0;
    tx_set = '0;
    for (int i = 0; i < RX_N; i++) rx_set[RX_CARRY_POS[i]] = rx_wrap[i];
    for (int i = 0; i < TX_N; i++) tx_set[TX_CARRY_POS[i]] = tx_wrap[i];
  end

  mac_stat_carry #(.REG_W(REG_W), .VALID(C1_VALID)) carry1_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (rx_set),
    .clr_wr  (wr_en && (addr == ADDR_W'(A_CARRY1))),
    .mask_wr (wr_en && (addr == ADDR_W'(A_MASK1))),
    .wdata   (wdata),
    .carry   (carry1_q),
    .mask    (mask1_q),
    .pend    (pend1)
  );

  mac_stat_carry #(.REG_W(REG_W), .VALID(C2_VALID)) carry2_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (tx_set),
    .clr_wr  (wr_en && (addr == ADDR_W'(A_CARRY2))),
    .mask_wr (wr_en && (addr == ADDR_W'(A_MASK2))),
    .wdata   (wdata),
    .carry   (carry2_q),
    .mask    (mask2_q),
    .pend    (pend2)
  );

  assign irq = pend1 | pend2;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < RX_N; i++)
      if (addr == ADDR_W'(A_RX_BASE + i)) rdata = REG_W'(rx_cnt[i]);
    for (int i = 0; i < TX_N; i++)
      if (addr == ADDR_W'(A_TX_BASE + i)) rdata = REG_W'(tx_cnt[i]);
    if (addr == ADDR_W'(A_CARRY1)) rdata = carry1_q;
    if (addr == ADDR_W'(A_CARRY2)) rdata = carry2_q;
    if (addr == ADDR_W'(A_MASK1))  rdata = mask1_q;
    if (addr == ADDR_W'(A_MASK2))  rdata = mask2_q;
  end
endmodule

// File: rtl/mac_stat_chk.sv
module mac_stat_chk
  import mac_stat_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  carry1_q,
  input logic [REG_W-1:0]  carry2_q,
  input logic [REG_W-1:0]  mask1_q,
  input logic [REG_W-1:0]  mask2_q,
  input logic              irq
);
  localparam logic [REG_W-1:0] C1_LEGAL = 32'h0000_41CD;
  localparam logic [REG_W-1:0] C2_LEGAL = 32'h0001_8174;

  // R3
  carry1_layout_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (carry1_q & ~C1_LEGAL) == '0);

  // R4
  carry2_layout_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (carry2_q & ~C2_LEGAL) == '0);

  // R6
  carry1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && addr == ADDR_W'(A_CARRY1)) |=> ((carry1_q & $past(carry1_q)) == $past(carry1_q)));

  // R6
  carry2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && addr == ADDR_W'(A_CARRY2)) |=> ((carry2_q & $past(carry2_q)) == $past(carry2_q)));

  // R7
  mask1_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == ADDR_W'(A_MASK1)) |=> mask1_q == $past(wdata));

  // R7
  mask2_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == ADDR_W'(A_MASK2)) |=> mask2_q == $past(wdata));

  // R8
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|(carry1_q & ~mask1_q)) || (|(carry2_q & ~mask2_q))) |-> irq);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (carry1_q == '0 && carry2_q == '0) |-> !irq);
endmodule

bind mac_stat_bank mac_stat_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .carry1_q   (carry1_q),
  .carry2_q   (carry2_q),
  .mask1_q    (mask1_q),
  .mask2_q    (mask2_q),
  .irq        (irq)
);

// File: tb/mac_stat_bank_tb.sv
module mac_stat_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  rx_evt = '0;
  logic [6:0]  tx_evt = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mac_stat_bank dut_i (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Expected layout, written from the requirements
  int rx_pos [7] = '{6, 8, 7, 0, 14, 3, 2};
  int tx_pos [7] = '{6, 8, 5, 4, 2, 16, 15};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    addr = 5'(a);
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] r, input logic [6:0] t);
    rx_evt = r; tx_evt = t;
    @(negedge clk);
    rx_evt = '0; tx_evt = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int exp_rx [7];
    int exp_tx [7];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state, unmapped addresses; R7: mask reset
    for (int a = 0; a < 32; a++) begin
      logic [31:0] e;
      e = (a == 18 || a == 19) ? 32'hFFFF_FFFF : 32'h0;
      rreg(a, v);
      check($sformatf("R10/R7 reset addr %0d", a), v, e);
    end
    check("R8 irq after reset", {31'h0, irq}, 32'h0);

    // Per-counter wrap sweep: R2, R3, R4, R5, R8, R9
    for (int k = 0; k < 14; k++) begin
      bit          is_rx;
      int          idx, a, w, pos, creg, mreg;
      logic [31:0] mx;
      logic [6:0]  ev;
      is_rx = (k < 7);
      idx   = k % 7;
      a     = is_rx ? idx : 8 + idx;
      w     = (is_rx && idx != 1) ? 16 : 12;
      mx    = (32'h1 << w) - 1;
      pos   = is_rx ? rx_pos[idx] : tx_pos[idx];
      creg  = is_rx ? 16 : 17;
      mreg  = is_rx ? 18 : 19;
      ev    = 7'(1 << idx);

      wreg(a, 32'hFFFF_FFFF);
      rreg(a, v); check($sformatf("R2 width ctr %0d", k), v, mx);
      wreg(a, mx - 1);
      rreg(a, v); check($sformatf("R9 load ctr %0d", k), v, mx - 1);
      if (is_rx) pulse(ev, '0); else pulse('0, ev);
      rreg(a, v); check($sformatf("R1 step ctr %0d", k), v, mx);
      rreg(creg, v); check($sformatf("R3/R4 no early carry ctr %0d", k), v, 32'h0);
      if (is_rx) pulse(ev, '0); else pulse('0, ev);
      rreg(a, v); check($sformatf("R2 wrap ctr %0d", k), v, 32'h0);
      rreg(creg, v);
      check($sformatf("%s carry pos ctr %0d", is_rx ? "R3" : "R4", k), v, 32'h1 << pos);
      check($sformatf("R8 masked ctr %0d", k), {31'h0, irq}, 32'h0);
      wreg(mreg, ~(32'h1 << pos));
      check($sformatf("R8 unmasked ctr %0d", k), {31'h0, irq}, 32'h1);
      wreg(creg, ~(32'h1 << pos));
      rreg(creg, v); check($sformatf("R5 zero bit kept ctr %0d", k), v, 32'h1 << pos);
      wreg(creg, 32'h1 << pos);
      rreg(creg, v); check($sformatf("R5 clear ctr %0d", k), v, 32'h0);
      check($sformatf("R8 cleared ctr %0d", k), {31'h0, irq}, 32'h0);
      wreg(mreg, 32'hFFFF_FFFF);
      rreg(mreg, v); check($sformatf("R7 mask restore ctr %0d", k), v, 32'hFFFF_FFFF);
    end

    // R1: mixed simultaneous event patterns
    for (int a = 0; a < 7; a++) begin wreg(a, 0); wreg(8 + a, 0); end
    for (int i = 0; i < 7; i++) begin exp_rx[i] = 0; exp_tx[i] = 0; end
    for (int c = 0; c < 48; c++) begin
      logic [6:0] r, t;
      r = 7'((c * 37 + 5) % 128);
      t = 7'((c * 53 + 11) % 128);
      for (int b = 0; b < 7; b++) begin exp_rx[b] += r[b]; exp_tx[b] += t[b]; end
      pulse(r, t);
    end
    for (int b = 0; b < 7; b++) begin
      rreg(b, v);     check($sformatf("R1 rx pattern ctr %0d", b), v, 32'(exp_rx[b]));
      rreg(8 + b, v); check($sformatf("R1 tx pattern ctr %0d", b), v, 32'(exp_tx[b]));
    end

    // R9: write wins over a same-cycle event; write of zero resets
    rx_evt = 7'b000_0100; wr_en = 1'b1; addr = 5'd2; wdata = 32'h1234;
    @(negedge clk); rx_evt = '0; wr_en = 1'b0;
    rreg(2, v); check("R9 write beats event", v, 32'h1234);
    tx_evt = 7'b000_0001; wr_en = 1'b1; addr = 5'd8; wdata = 32'h0;
    @(negedge clk); tx_evt = '0; wr_en = 1'b0;
    rreg(8, v); check("R9 zero write resets", v, 32'h0);

    // R5: wrap and clear of the same carry bit in one cycle
    wreg(0, 32'hFFFF);
    pulse(7'b000_0001, '0);
    rreg(16, v); check("R3 fcs carry bit 6", v, 32'h40);
    wreg(0, 32'hFFFF);
    rx_evt = 7'b000_0001; wr_en = 1'b1; addr = 5'd16; wdata = 32'h40;
    @(negedge clk); rx_evt = '0; wr_en = 1'b0;
    rreg(16, v); check("R5 wrap beats clear", v, 32'h40);

    // R6: sticky under further events; unimplemented bits stay zero
    pulse(7'b111_1111, 7'b111_1111);
    wreg(16, 32'hFFFF_FFBF);
    rreg(16, v); check("R6 sticky carry1", v, 32'h40);
    wreg(16, 32'hFFFF_FFFF);
    rreg(16, v); check("R6 cleared carry1", v, 32'h0);
    wreg(17, 32'hFFFF_FFFF);
    rreg(17, v); check("R6 carry2 no stray bits", v, 32'h0);

    // R2: natural wrap of the 12-bit alignment counter
    wreg(1, 0);
    for (int i = 0; i < 4095; i++) pulse(7'b000_0010, '0);
    rreg(1, v); check("R2 align at 0xFFF", v, 32'hFFF);
    rreg(16, v); check("R3 no carry before wrap", v, 32'h0);
    pulse(7'b000_0010, '0);
    rreg(1, v); check("R2 align natural wrap", v, 32'h0);
    rreg(16, v); check("R3 align carry bit 8", v, 32'h100);
    wreg(18, 32'hFFFF_BE32);
    check("R8 irq with typical mask", {31'h0, irq}, 32'h1);

    finish_run();
  end
endmodule